// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a two-part logical address, made of a segment number and an offset inside that segment, into a physical address. It does this through a small table held in flops. Each table slot describes one segment. A slot holds a physical base, a length limit, three permission bits (read, write, execute) and a valid flag. A request gives the segment number, the offset and the kind of access. One clock later the block returns either a physical address with a valid strobe or a fault strobe with a cause code.

The table is loaded through a separate write port. That port only takes effect while the privileged qualifier is high, so unprivileged software cannot move or widen its own segments. A slot written in one cycle governs requests issued from the next cycle on. Widths, the number of slots and the segment-number width are parameters. The default logical address is a 3-bit segment number above a 29-bit offset, and the physical address is 32 bits.

Top module: `seg_xlate`

## Requirements
- R1: For a request with no fault, `pa_valid` is high on the cycle after the request, and `pa` equals the slot base plus the zero-extended offset, modulo 2^32.
- R2: An offset greater than or equal to the slot limit raises a fault with cause 2'b01 (bounds). A limit of zero makes every offset fault.
- R3: The access type is read = 0, write = 1, execute = 2 and reserved = 3. It is checked against the permission bits: bit 0 allows read, bit 1 allows write, bit 2 allows execute. Reserved is never allowed. A type that is not allowed raises cause 2'b10 (protection).
- R4: A request to a slot whose valid flag is clear raises cause 2'b11 (segment).
- R5: When several faults apply, the segment fault wins over the bounds fault, and the bounds fault wins over the protection fault.
- R6: During a fault, `flt_valid` is high, `pa_valid` is low and `pa` reads zero. `pa_valid` and `flt_valid` are never high together.
- R7: A table write with `tw_priv` low changes no slot. A later request to that slot returns the same result as before the write.
- R8: A privileged write governs requests issued on the following cycle and after. A request issued in the same cycle as the write sees the slot's old contents.
- R9: After reset every slot is invalid and both strobes are low.
- R10: In a cycle following one with no request, `pa_valid` and `flt_valid` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_seg | input | 3 | Segment number |
| req_off | input | 29 | Offset within the segment |
| req_acc | input | 2 | Access type (0 read, 1 write, 2 execute, 3 reserved) |
| tw_en | input | 1 | Table write strobe |
| tw_priv | input | 1 | Privileged qualifier for the table write |
| tw_idx | input | 3 | Slot to write |
| tw_valid | input | 1 | Valid flag to store |
| tw_perm | input | 3 | Permission bits to store (bit0 R, bit1 W, bit2 X) |
| tw_base | input | 32 | Physical base to store |
| tw_limit | input | 29 | Segment length to store |
| pa_valid | output | 1 | Physical address valid |
| pa | output | 32 | Physical address |
| flt_valid | output | 1 | Fault strobe |
| flt_cause | output | 2 | Fault cause (01 bounds, 10 protection, 11 segment) |

## Verification
The hardest case to reach from the ports is a table write and a request to the same slot in the same cycle. The old contents must answer the request, and the new contents must answer the next one. The bench drives both strobes on one clock edge and then repeats the request on the next edge. Fault priority is hard to observe because each fault hides the ones below it. The bench therefore sets up one slot with a zero limit, and another with no permissions and a small limit. With those two slots, the bounds and protection conditions can be applied together and apart.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_EXEC  = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_e;

   typedef enum logic [1:0] {
      CAUSE_NONE   = 2'd0,
      CAUSE_BOUNDS = 2'd1,
      CAUSE_PROT   = 2'd2,
      CAUSE_SEG    = 2'd3
   } cause_e;

   localparam int PERM_R = 0;
   localparam int PERM_W = 1;
   localparam int PERM_X = 2;

endpackage

// File: rtl/seg_table.sv
module seg_table #(
   parameter int SEG_BITS = 3,
   parameter int OFF_BITS = 29,
   parameter int PA_BITS  = 32,
   parameter int ENTRIES  = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic                wr_priv,
   input  logic [SEG_BITS-1:0] wr_idx,
   input  logic                wr_vld,
   input  logic [2:0]          wr_perm,
   input  logic [PA_BITS-1:0]  wr_base,
   input  logic [OFF_BITS-1:0] wr_lim,
   input  logic [SEG_BITS-1:0] rd_idx,
   output logic                rd_hit,
   output logic [2:0]          rd_perm,
   output logic [PA_BITS-1:0]  rd_base,
   output logic [OFF_BITS-1:0] rd_lim
);

   localparam int SLOTS_MAX = 1 << SEG_BITS;

   if (ENTRIES < 1 || ENTRIES > SLOTS_MAX) begin : g_bad_entries
      $error("seg_table: ENTRIES must lie in 1..2**SEG_BITS");
   end

   logic [ENTRIES-1:0]               vld_q;
   logic [ENTRIES-1:0][2:0]          perm_q;
   logic [ENTRIES-1:0][PA_BITS-1:0]  base_q;
   logic [ENTRIES-1:0][OFF_BITS-1:0] lim_q;

   logic wr_go;
   assign wr_go = wr_en && wr_priv;

   for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q[i]  <= 1'b0;
            perm_q[i] <= '0;
            base_q[i] <= '0;
            lim_q[i]  <= '0;
         end else if (wr_go && wr_idx == SEG_BITS'(i)) begin
            vld_q[i]  <= wr_vld;
            perm_q[i] <= wr_perm;
            base_q[i] <= wr_base;
            lim_q[i]  <= wr_lim;
         end
      end
   end

   logic in_rng;
   if (ENTRIES == SLOTS_MAX) begin : g_full
      assign in_rng = 1'b1;
   end else begin : g_part
      assign in_rng = (rd_idx < SEG_BITS'(ENTRIES));
   end

   always_comb begin
      rd_hit  = 1'b0;
      rd_perm = '0;
      rd_base = '0;
      rd_lim  = '0;
      if (in_rng) begin
         rd_hit  = vld_q[rd_idx];
         rd_perm = perm_q[rd_idx];
         rd_base = base_q[rd_idx];
         rd_lim  = lim_q[rd_idx];
      end
   end

   // R7: unprivileged or absent writes leave every slot untouched
   assert_unpriv_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_go |=> ($stable(vld_q) && $stable(perm_q) && $stable(base_q) && $stable(lim_q)));

endmodule

// File: rtl/seg_check.sv
module seg_check
   import seg_xlate_pkg::*;
#(
   parameter int OFF_BITS = 29,
   parameter int PA_BITS  = 32
) (
   input  logic                hit,
   input  logic [2:0]          perm,
   input  logic [PA_BITS-1:0]  base,
   input  logic [OFF_BITS-1:0] lim,
   input  logic [OFF_BITS-1:0] off,
   input  logic [1:0]          acc,
   output logic                ok,
   output cause_e              cause,
   output logic [PA_BITS-1:0]  pa
);

   if (OFF_BITS > PA_BITS) begin : g_bad_widths
      $error("seg_check: OFF_BITS must not exceed PA_BITS");
   end

   logic [PA_BITS-1:0] off_ext;
   if (OFF_BITS == PA_BITS) begin : g_same
      assign off_ext = off;
   end else begin : g_ext
      assign off_ext = {{(PA_BITS-OFF_BITS){1'b0}}, off};
   end

   logic bnd_bad;
   logic acc_ok;

   assign bnd_bad = (off >= lim);

   always_comb begin
      unique case (acc_e'(acc))
         ACC_READ:  acc_ok = perm[PERM_R];
         ACC_WRITE: acc_ok = perm[PERM_W];
         ACC_EXEC:  acc_ok = perm[PERM_X];
         default:   acc_ok = 1'b0;
      endcase
   end

   always_comb begin
      if (!hit)         cause = CAUSE_SEG;
      else if (bnd_bad) cause = CAUSE_BOUNDS;
      else if (!acc_ok) cause = CAUSE_PROT;
      else              cause = CAUSE_NONE;
   end

   assign ok = (cause == CAUSE_NONE);
   assign pa = base + off_ext;

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
   import seg_xlate_pkg::*;
#(
   parameter int SEG_BITS = 3,
   parameter int OFF_BITS = 29,
   parameter int PA_BITS  = 32,
   parameter int ENTRIES  = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [SEG_BITS-1:0] req_seg,
   input  logic [OFF_BITS-1:0] req_off,
   input  logic [1:0]          req_acc,
   input  logic                tw_en,
   input  logic                tw_priv,
   input  logic [SEG_BITS-1:0] tw_idx,
   input  logic                tw_valid,
   input  logic [2:0]          tw_perm,
   input  logic [PA_BITS-1:0]  tw_base,
   input  logic [OFF_BITS-1:0] tw_limit,
   output logic                pa_valid,
   output logic [PA_BITS-1:0]  pa,
   output logic                flt_valid,
   output logic [1:0]          flt_cause
);

   localparam int LA_BITS = SEG_BITS + OFF_BITS;

   if (SEG_BITS < 1 || LA_BITS > 64) begin : g_bad_la
      $error("seg_xlate: logical address split out of range");
   end

   logic                hit;
   logic [2:0]          perm;
   logic [PA_BITS-1:0]  base;
   logic [OFF_BITS-1:0] lim;
   logic                ok;
   cause_e              cause;
   logic [PA_BITS-1:0]  pa_d;

   seg_table #(
      .SEG_BITS(SEG_BITS), .OFF_BITS(OFF_BITS),
      .PA_BITS(PA_BITS),   .ENTRIES(ENTRIES)
   ) u_tbl (
      .clk(clk), .rst_n(rst_n),
      .wr_en(tw_en), .wr_priv(tw_priv), .wr_idx(tw_idx),
      .wr_vld(tw_valid), .wr_perm(tw_perm), .wr_base(tw_base), .wr_lim(tw_limit),
      .rd_idx(req_seg),
      .rd_hit(hit), .rd_perm(perm), .rd_base(base), .rd_lim(lim)
   );

   seg_check #(
      .OFF_BITS(OFF_BITS), .PA_BITS(PA_BITS)
   ) u_chk (
      .hit(hit), .perm(perm), .base(base), .lim(lim),
      .off(req_off), .acc(req_acc),
      .ok(ok), .cause(cause), .pa(pa_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pa_valid  <= 1'b0;
         pa        <= '0;
         flt_valid <= 1'b0;
         flt_cause <= CAUSE_NONE;
      end else begin
         pa_valid  <= req_valid && ok;
         flt_valid <= req_valid && !ok;
         pa        <= (req_valid && ok) ? pa_d : '0;
         flt_cause <= (req_valid && !ok) ? cause : CAUSE_NONE;
      end
   end

   // R6: address and fault strobes are exclusive
   assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(pa_valid && flt_valid));

   // R6: a fault always carries a nonzero cause and a zeroed address
   assert_fault_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      flt_valid |-> (flt_cause != CAUSE_NONE && pa == '0));

   // R10: no request, no response
   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!pa_valid && !flt_valid));

   // R4: an address is only produced from a valid slot
   assert_valid_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !hit) |=> (flt_valid && flt_cause == CAUSE_SEG));

   // R2: an offset at or past the limit never produces an address
   assert_bounds_block_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_off >= lim) |=> !pa_valid);

endmodule

// File: tb/sim_seg_xlate.sv
module sim_seg_xlate;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_seg = '0;
   logic [28:0] req_off = '0;
   logic [1:0]  req_acc = '0;
   logic        tw_en = 1'b0;
   logic        tw_priv = 1'b0;
   logic [2:0]  tw_idx = '0;
   logic        tw_valid = 1'b0;
   logic [2:0]  tw_perm = '0;
   logic [31:0] tw_base = '0;
   logic [28:0] tw_limit = '0;
   logic        pa_valid;
   logic [31:0] pa;
   logic        flt_valid;
   logic [1:0]  flt_cause;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   seg_xlate u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_seg(req_seg), .req_off(req_off), .req_acc(req_acc),
      .tw_en(tw_en), .tw_priv(tw_priv), .tw_idx(tw_idx), .tw_valid(tw_valid),
      .tw_perm(tw_perm), .tw_base(tw_base), .tw_limit(tw_limit),
      .pa_valid(pa_valid), .pa(pa), .flt_valid(flt_valid), .flt_cause(flt_cause)
   );

   // {seg, off, acc, expected cause (0 = translation), expected pa}
   localparam logic [67:0] VEC [12] = '{
      {3'd0, 29'h000,   2'd0, 2'd0, 32'h1000_0000},  // R1 read code
      {3'd0, 29'h0FF,   2'd2, 2'd0, 32'h1000_00FF},  // R1 exec last byte
      {3'd0, 29'h010,   2'd1, 2'd2, 32'h0000_0000},  // R3 write to read-only
      {3'd0, 29'h100,   2'd0, 2'd1, 32'h0000_0000},  // R2 offset == limit
      {3'd1, 29'hFFF,   2'd1, 2'd0, 32'h2000_0FFF},  // R1 data write
      {3'd1, 29'h004,   2'd2, 2'd2, 32'h0000_0000},  // R3 exec of data
      {3'd2, 29'h1FF,   2'd0, 2'd0, 32'h0000_00FF},  // R1 wraps mod 2^32
      {3'd3, 29'h000,   2'd0, 2'd3, 32'h0000_0000},  // R4 never written
      {3'd7, 29'h000,   2'd0, 2'd1, 32'h0000_0000},  // R2 zero limit
      {3'd5, 29'h020,   2'd0, 2'd1, 32'h0000_0000},  // R5 bounds over prot
      {3'd5, 29'h000,   2'd0, 2'd2, 32'h0000_0000},  // R3 no perms
      {3'd1, 29'h000,   2'd3, 2'd2, 32'h0000_0000}   // R3 reserved type
   };

   task automatic chk(input string tag, input logic e_pv, input logic [31:0] e_pa,
                      input logic e_fv, input logic [1:0] e_c);
      n_chk++;
      if (pa_valid !== e_pv || pa !== e_pa || flt_valid !== e_fv || flt_cause !== e_c) begin
         n_bad++;
         $display("FAIL %s: got pv=%0b pa=%h fv=%0b cause=%0d, expected pv=%0b pa=%h fv=%0b cause=%0d",
                  tag, pa_valid, pa, flt_valid, flt_cause, e_pv, e_pa, e_fv, e_c);
      end
   endtask

   task automatic wr(input logic priv, input logic [2:0] idx, input logic v,
                     input logic [2:0] p, input logic [31:0] b, input logic [28:0] l);
      @(negedge clk);
      tw_en = 1'b1; tw_priv = priv; tw_idx = idx; tw_valid = v;
      tw_perm = p; tw_base = b; tw_limit = l;
      @(negedge clk);
      tw_en = 1'b0; tw_priv = 1'b0;
   endtask

   task automatic rq(input logic [2:0] s, input logic [28:0] o, input logic [1:0] a);
      @(negedge clk);
      req_valid = 1'b1; req_seg = s; req_off = o; req_acc = a;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic finish_up();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got hang, expected completion");
         finish_up();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 reset outputs", 1'b0, 32'h0, 1'b0, 2'd0);
      rq(3'd0, 29'h0, 2'd0);
      chk("R9 slots invalid after reset", 1'b0, 32'h0, 1'b1, 2'd3);

      wr(1'b1, 3'd0, 1'b1, 3'b101, 32'h1000_0000, 29'h100);
      wr(1'b1, 3'd1, 1'b1, 3'b011, 32'h2000_0000, 29'h1000);
      wr(1'b1, 3'd2, 1'b1, 3'b111, 32'hFFFF_FF00, 29'h200);
      wr(1'b1, 3'd7, 1'b1, 3'b111, 32'h0000_4000, 29'h0);
      wr(1'b1, 3'd5, 1'b1, 3'b000, 32'h8000_0000, 29'h10);

      for (int i = 0; i < 12; i++) begin
         logic [67:0] v;
         v = VEC[i];
         rq(v[67:65], v[64:36], v[35:34]);
         if (v[33:32] == 2'd0)
            chk($sformatf("R1/R3 vector %0d", i), 1'b1, v[31:0], 1'b0, 2'd0);
         else
            chk($sformatf("R2/R3/R4/R5/R6 vector %0d", i), 1'b0, 32'h0, 1'b1, v[33:32]);
      end

      // R10: idle cycle gives no strobes
      @(negedge clk);
      chk("R10 idle", 1'b0, 32'h0, 1'b0, 2'd0);

      // R7: unprivileged write to slot 3 is ignored
      wr(1'b0, 3'd3, 1'b1, 3'b111, 32'h3000_0000, 29'h100);
      rq(3'd3, 29'h0, 2'd0);
      chk("R7 unprivileged write ignored", 1'b0, 32'h0, 1'b1, 2'd3);
      // R7: unprivileged overwrite of slot 1 leaves old mapping
      wr(1'b0, 3'd1, 1'b0, 3'b000, 32'h0, 29'h0);
      rq(3'd1, 29'h8, 2'd0);
      chk("R7 slot 1 unchanged", 1'b1, 32'h2000_0008, 1'b0, 2'd0);

      // R8: same-cycle write and request sees old slot; next cycle sees new
      @(negedge clk);
      tw_en = 1'b1; tw_priv = 1'b1; tw_idx = 3'd6; tw_valid = 1'b1;
      tw_perm = 3'b001; tw_base = 32'h6000_0000; tw_limit = 29'h40;
      req_valid = 1'b1; req_seg = 3'd6; req_off = 29'h4; req_acc = 2'd0;
      @(negedge clk);
      tw_en = 1'b0; tw_priv = 1'b0;
      chk("R8 same-cycle request sees old slot", 1'b0, 32'h0, 1'b1, 2'd3);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R8 next-cycle request sees new slot", 1'b1, 32'h6000_0004, 1'b0, 2'd0);

      // R4: invalidating a slot turns hits into segment faults
      wr(1'b1, 3'd0, 1'b0, 3'b111, 32'h1000_0000, 29'h100);
      rq(3'd0, 29'h0, 2'd0);
      chk("R4 invalidated slot", 1'b0, 32'h0, 1'b1, 2'd3);

      // R5: segment fault wins over bounds and protection on invalid slot
      rq(3'd0, 29'h1FFF_FFFF, 2'd3);
      chk("R5 segment first", 1'b0, 32'h0, 1'b1, 2'd3);

      // R2: largest in-range offset translates, one past does not
      rq(3'd6, 29'h3F, 2'd0);
      chk("R2 last offset", 1'b1, 32'h6000_003F, 1'b0, 2'd0);
      rq(3'd6, 29'h40, 2'd0);
      chk("R2 one past limit", 1'b0, 32'h0, 1'b1, 2'd1);

      // R10: response lasts one cycle
      @(negedge clk);
      chk("R10 strobe drops", 1'b0, 32'h0, 1'b0, 2'd0);

      done = 1'b1;
      finish_up();
   end

endmodule